// File: doc/BRIEF.md
# I2C Clock Phase Timer

This block times the two halves of the clock line for an I2C master. Four count inputs hold the figures for the high and low halves in each of two bus speeds: a standard pair and a fast pair. A speed select decides which pair applies. The block drives the clock line in open-drain fashion. Asserting `scl_oe` pulls the line low, and deasserting it lets the pull-up raise the line. The block also reads the real line level back on `scl_in`.

A low half begins on the cycle the block starts pulling the line. It lasts the low figure plus one cycle, so the figure written must already allow for the fall time. After release, the high half does not start counting until the line is seen high. This lets a slave stretch the clock by holding the line low. From that first high sample, the high half lasts the high figure plus a fixed overhead of 8 cycles.

Two single-cycle strobes tell a byte engine where the edges fall. One marks the cycle the line is first seen high, which is the sampling point. The other marks the first cycle of each low half, which is the point where the data line may change. The counts and the speed select are captured only while `en` is low. They are frozen for as long as the block runs.

Top module: `scl_period_gen`

## Requirements
- R1: While `rst_n` is low, `scl_oe`, `rise_stb` and `fall_stb` are all 0.
- R2: In every cycle that follows a cycle with `en` low, `scl_oe`, `rise_stb` and `fall_stb` are 0. Lowering `en` in the middle of a period releases the line on the next cycle.
- R3: The first cycle after `en` rises starts a low half. Every low half holds `scl_oe` at 1 for exactly L+1 consecutive cycles, where L is the captured low figure.
- R4: If the line rises as soon as it is released, the line stays released for exactly H+8 cycles, where H is the captured high figure. The next low half then begins.
- R5: While the line is released but `scl_in` stays 0, the high half does not start. The release is lengthened by exactly the number of cycles that `scl_in` stays 0. Once the first high sample has been taken, `scl_in` has no effect on the high half.
- R6: When `fast_mode` is 1 at capture time, the high and low figures come from `fast_hi` and `fast_lo`. When it is 0, they come from `std_hi` and `std_lo`.
- R7: Any captured figure below 6 is treated as 6. This applies to both the high and the low figure.
- R8: Changes on the count inputs or on `fast_mode` while `en` is high have no effect on the timing until `en` has been low for at least one cycle.
- R9: `fall_stb` is 1 only in the first cycle of each low half. `rise_stb` is 1 only in the released cycle in which `scl_in` is first seen high. The two strobes are never 1 together.
- R10: Count inputs are captured on every clock edge at which `en` is low. The reset value of each captured figure is 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run when high; capture the figures and release the line when low |
| fast_mode | input | 1 | 1 selects the fast pair, 0 selects the standard pair |
| std_hi | input | CNT_W | High figure, standard speed |
| std_lo | input | CNT_W | Low figure, standard speed |
| fast_hi | input | CNT_W | High figure, fast speed |
| fast_lo | input | CNT_W | Low figure, fast speed |
| scl_in | input | 1 | Synchronised level of the clock line |
| scl_oe | output | 1 | 1 pulls the clock line low |
| rise_stb | output | 1 | Sampling strobe at the observed rising edge |
| fall_stb | output | 1 | Update strobe at the start of each low half |

## Verification
The hardest case to reach is a slave that stretches the clock. It needs `scl_in` held low exactly while the block has released the line, and then freed at varied points. The bench models the line as the wired-AND of `scl_oe` with a stretch control of its own. It holds that control low across many different release windows, so the wait for the first high sample varies in length. The same run also moves the count inputs and the speed select while `en` is high, to show that the frozen figures are kept.

// File: rtl/scl_period_gen.sv
module scl_period_gen #(
  parameter int CNT_W   = 16,
  parameter int MIN_CNT = 6,
  parameter int HI_OVH  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             fast_mode,
  input  logic [CNT_W-1:0] std_hi,
  input  logic [CNT_W-1:0] std_lo,
  input  logic [CNT_W-1:0] fast_hi,
  input  logic [CNT_W-1:0] fast_lo,
  input  logic             scl_in,
  output logic             scl_oe,
  output logic             rise_stb,
  output logic             fall_stb
);
  localparam int CW = CNT_W + 1;
  localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_CNT);

  typedef enum logic [1:0] {S_OFF, S_LOW, S_REL, S_HIGH} st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [CNT_W-1:0] lo_q, hi_q;

  wire [CNT_W-1:0] lo_sel = fast_mode ? fast_lo : std_lo;
  wire [CNT_W-1:0] hi_sel = fast_mode ? fast_hi : std_hi;
  wire [CNT_W-1:0] lo_eff = (lo_sel < FLOOR) ? FLOOR : lo_sel;
  wire [CNT_W-1:0] hi_eff = (hi_sel < FLOOR) ? FLOOR : hi_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_OFF;
      cnt  <= '0;
      lo_q <= FLOOR;
      hi_q <= FLOOR;
    end else if (!en) begin
      st   <= S_OFF;
      cnt  <= '0;
      lo_q <= lo_eff;
      hi_q <= hi_eff;
    end else begin
      case (st)
        S_OFF: begin
          st  <= S_LOW;
          cnt <= CW'(lo_q);
        end
        S_LOW: begin
          if (cnt == '0) st <= S_REL;
          else           cnt <= cnt - 1'b1;
        end
        S_REL: begin
          if (scl_in) begin
            st  <= S_HIGH;
            cnt <= CW'(hi_q) + CW'(HI_OVH - 2);
          end
        end
        default: begin
          if (cnt == '0) begin
            st  <= S_LOW;
            cnt <= CW'(lo_q);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end

  assign scl_oe   = (st == S_LOW);
  assign fall_stb = (st == S_LOW) && (cnt == CW'(lo_q));
  assign rise_stb = (st == S_REL) && scl_in;
endmodule

module scl_period_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic scl_in,
  input logic scl_oe,
  input logic rise_stb,
  input logic fall_stb
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (!scl_oe && !rise_stb && !fall_stb));

  p_off_released_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_oe && !rise_stb && !fall_stb));

  p_low_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(scl_oe) && en) |=> scl_oe);

  p_fall_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> fall_stb);

  p_fall_driven_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> scl_oe);

  p_rise_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> (!scl_oe && scl_in));

  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_stb && fall_stb));

  p_high_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |=> (!scl_oe && !rise_stb));
endmodule

bind scl_period_gen scl_period_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .scl_in(scl_in),
  .scl_oe(scl_oe), .rise_stb(rise_stb), .fall_stb(fall_stb)
);

// File: tb/scl_period_gen_tb.sv
module scl_period_gen_tb;
  localparam int CNT_W = 16;

  logic clk = 0, rst_n = 0, en = 0, fast_mode = 0, stretch = 0;
  logic [CNT_W-1:0] std_hi = 10, std_lo = 20, fast_hi = 7, fast_lo = 9;
  logic scl_oe, rise_stb, fall_stb, scl_in;

  assign scl_in = !scl_oe && !stretch;

  scl_period_gen #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .fast_mode(fast_mode),
    .std_hi(std_hi), .std_lo(std_lo), .fast_hi(fast_hi), .fast_lo(fast_lo),
    .scl_in(scl_in), .scl_oe(scl_oe), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  always #10 clk = ~clk;

  int vectors = 0, errors = 0;
  string cur_req = "R1";
  bit done = 0;

  // reference model: phase 0 off, 1 pulled low, 2 released
  int ph = 0, el = 0, hi = 0, L = 6, H = 6;

  function automatic int floor6(int v);
    return (v < 6) ? 6 : v;
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      #4;
      begin
        bit eo, ef, er;
        eo = (ph == 1);
        ef = (ph == 1) && (el == 0);
        er = (ph == 2) && (hi == 0) && scl_in;
        vectors++;
        if (scl_oe !== eo || fall_stb !== ef || rise_stb !== er) begin
          errors++;
          $display("FAIL %s t=%0t: oe/fall/rise=%b%b%b expected %b%b%b",
                   cur_req, $time, scl_oe, fall_stb, rise_stb, eo, ef, er);
        end
      end
      #12;
      if (!rst_n) begin
        ph = 0; el = 0; hi = 0; L = 6; H = 6;
      end else if (!en) begin
        ph = 0; el = 0; hi = 0;
        L = floor6(int'(fast_mode ? fast_lo : std_lo));
        H = floor6(int'(fast_mode ? fast_hi : std_hi));
      end else begin
        case (ph)
          0: begin ph = 1; el = 0; end
          1: begin
            if (el == L) begin ph = 2; hi = 0; end
            else el++;
          end
          default: begin
            if (hi > 0 || scl_in) begin
              if (hi + 1 == H + 8) begin ph = 1; el = 0; hi = 0; end
              else hi++;
            end
          end
        endcase
      end
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // R1 reset state
    cur_req = "R1";
    wait_cyc(5);
    rst_n = 1;
    // R2 and R10: disabled, inputs moving, line stays released
    cur_req = "R2/R10";
    for (int i = 0; i < 10; i++) begin
      std_lo = CNT_W'(i); fast_hi = CNT_W'(30 - i);
      @(negedge clk);
    end
    std_hi = 10; std_lo = 20; fast_hi = 7; fast_lo = 9;
    wait_cyc(2);
    // R3 R4 R9 standard pair, no stretching
    cur_req = "R3/R4/R9";
    en = 1;
    wait_cyc(220);
    // R6 fast pair
    cur_req = "R6";
    en = 0; fast_mode = 1;
    wait_cyc(2);
    en = 1;
    wait_cyc(150);
    // R7 floors on both figures
    cur_req = "R7";
    en = 0; fast_lo = 2; fast_hi = 0;
    wait_cyc(3);
    en = 1;
    wait_cyc(120);
    // R8 changes while running are ignored
    cur_req = "R8";
    fast_mode = 0; std_lo = 40; std_hi = 33; fast_lo = 11;
    wait_cyc(120);
    // R5 slave stretching with varied hold lengths
    cur_req = "R5";
    en = 0; fast_mode = 0; std_lo = 8; std_hi = 6;
    wait_cyc(2);
    en = 1;
    for (int k = 0; k < 12; k++) begin
      stretch = 1;
      wait_cyc(3 + 5 * k);
      stretch = 0;
      wait_cyc(7 + k);
    end
    // R2 abort in the middle of a low half
    cur_req = "R2";
    wait_cyc(1);
    while (!scl_oe) @(negedge clk);
    wait_cyc(3);
    en = 0;
    wait_cyc(6);
    en = 1;
    wait_cyc(60);
    en = 0;
    wait_cyc(5);
    // R1 reset again mid-run
    cur_req = "R1";
    en = 1;
    wait_cyc(12);
    rst_n = 0;
    wait_cyc(4);
    rst_n = 1;
    wait_cyc(40);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule